// File: doc/BRIEF.md
# Bus-Attached Watchdog Timer with Reset-Cause Latch

This peripheral sits on an APB slave port and guards the system with a 24-bit down-counter. The counter steps down once per microsecond tick from a generator outside the block. When the count runs out, or when software forces it, the block raises a one-cycle reset-request pulse toward the system reset controller. It also latches whether that request came from a timeout or from the software force. The counter freezes while the block is disabled. Software can also choose to freeze it while either processor core is halted by the debugger, or while a JTAG probe is using the bus fabric.

Two resets reach the block. `por_n` is the hardware power-on reset and clears everything. `sys_rst_n` is the soft system reset that the watchdog itself brings about. It returns the control state and the counter to their defaults, but leaves the eight scratch words and the cause latch alone. The integration must assert `sys_rst_n` whenever `por_n` is asserted. A debugger warm-reset request for either core wipes the cause latch, so that freshly loaded code does not see an old timeout. APB is the only handshaked interface. `pready` is tied high, so the slave never applies back-pressure and every access takes exactly a setup cycle and an access cycle. The reset request and the debug inputs are plain level or pulse signals.

Top module: `apb_wdog`

## Requirements
- R1: After `por_n`, the control word reads 0x07000000, the cause word and all scratch words read 0, and `wdog_rst_req` is low.
- R2: Control bits 23:0 read the live count. A write to offset 0x04 loads bits 23:0 of the written data into the count, and offset 0x04 always reads 0. Otherwise, each cycle with `tick_us` high lowers a nonzero count by one, provided counting is enabled and not paused. A load and a tick in the same cycle give the load value.
- R3: Control bit 30 enables counting. While it is 0 the count holds.
- R4: The pause-enable bits are control bit 26 (core 1 halted, `core_halt[1]`), bit 25 (core 0 halted, `core_halt[0]`) and bit 24 (JTAG active, `jtag_busy`). A tick is ignored only when a pause-enable bit is 1 and its condition input is high.
- R5: A tick that takes the count from 1 to 0 pulses `wdog_rst_req` for one cycle after that clock edge and sets the cause word to 01 (bit 0 = timeout). The count then stays 0 until it is loaded again.
- R6: Writing control with bit 31 set pulses `wdog_rst_req` for one cycle, whatever the count, and sets the cause word to 10 (bit 1 = forced). Bit 31 always reads 0. If a force and an expiry fall in the same cycle, the cause is 10.
- R7: A high bit on `dbg_warm_rst[1:0]` clears the cause word to 00, unless a force or expiry happens in the same cycle.
- R8: Scratch word k (k = 0..7) is read/write at offset 0x0C + 4k. Scratch words and the cause word survive `sys_rst_n` and are cleared only by `por_n`.
- R9: `pready` is always 1 and `pslverr` always 0. Writes to the cause word, to the count field and to unused control bits change nothing. Unmapped or unaligned addresses read 0 and ignore writes.
- R10: `sys_rst_n` returns the control word to 0x07000000 with a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Hardware reset, active low, clears all state |
| sys_rst_n | input | 1 | Soft system reset, active low, clears control and count |
| tick_us | input | 1 | One-cycle microsecond tick |
| core_halt | input | 2 | Debug-halt status, bit 0 core 0, bit 1 core 1 |
| jtag_busy | input | 1 | JTAG probe is using the bus |
| dbg_warm_rst | input | 2 | Debugger warm-reset request per core |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, constant 1 |
| pslverr | output | 1 | APB error, constant 0 |
| wdog_rst_req | output | 1 | One-cycle reset request |

## Verification
A write to control or load takes effect at the clock edge that ends its access cycle. The count, the cause word and `wdog_rst_req` all change one register stage after that edge. The same single-stage delay applies to a tick that expires the count. Read data is combinational and is valid during the access cycle. The bench drives every input one time unit after the rising edge. It advances a behavioural model on the same rising edge from those inputs and compares at the falling edge. There, `wdog_rst_req` is checked every cycle and `prdata` in every read access cycle, so any result that arrives a cycle early or late shows up as a mismatch. Directed reads add hand-computed values for the tick, pause, expiry, priority and reset cases.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned WD_DATA_W = 32;

  // byte offsets of the register words
  localparam int unsigned OFS_CTRL   = 'h00;
  localparam int unsigned OFS_LOAD   = 'h04;
  localparam int unsigned OFS_CAUSE  = 'h08;
  localparam int unsigned OFS_SCR0   = 'h0C;

  // control bit positions
  localparam int unsigned BIT_FORCE  = 31;
  localparam int unsigned BIT_EN     = 30;
  localparam int unsigned BIT_PZ_C1  = 26;
  localparam int unsigned BIT_PZ_C0  = 25;
  localparam int unsigned BIT_PZ_JT  = 24;

  typedef struct packed {
    logic en;
    logic pz_core1;
    logic pz_core0;
    logic pz_jtag;
  } wd_ctrl_t;

  localparam wd_ctrl_t CTRL_DEFAULT = '{en: 1'b0, pz_core1: 1'b1, pz_core0: 1'b1, pz_jtag: 1'b1};

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_TIMER  = 2'b01,
    CAUSE_FORCED = 2'b10
  } wd_cause_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned N_SCR  = 8
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 sys_rst_n,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [WD_DATA_W-1:0] pwdata,
  input  logic [CNT_W-1:0]     count,
  input  logic [1:0]           cause,
  output logic [WD_DATA_W-1:0] prdata,
  output wd_ctrl_t             ctrl,
  output logic                 load_wr,
  output logic [CNT_W-1:0]     load_val,
  output logic                 force_wr
);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_LOAD  = ADDR_W'(OFS_LOAD);
  localparam logic [ADDR_W-1:0] A_CAUSE = ADDR_W'(OFS_CAUSE);

  logic wr_acc;
  logic ctrl_wr;
  assign wr_acc   = psel & penable & pwrite;
  assign ctrl_wr  = wr_acc & (paddr == A_CTRL);
  assign load_wr  = wr_acc & (paddr == A_LOAD);
  assign load_val = pwdata[CNT_W-1:0];
  assign force_wr = ctrl_wr & pwdata[BIT_FORCE];

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      ctrl <= CTRL_DEFAULT;
    end else if (ctrl_wr) begin
      ctrl.en       <= pwdata[BIT_EN];
      ctrl.pz_core1 <= pwdata[BIT_PZ_C1];
      ctrl.pz_core0 <= pwdata[BIT_PZ_C0];
      ctrl.pz_jtag  <= pwdata[BIT_PZ_JT];
    end
  end

  logic [WD_DATA_W-1:0] scr_q [N_SCR];
  logic [N_SCR-1:0]     scr_hit;

  for (genvar k = 0; k < N_SCR; k++) begin : g_scr
    assign scr_hit[k] = (paddr == ADDR_W'(OFS_SCR0 + 4 * k));
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        scr_q[k] <= '0;
      end else if (wr_acc && scr_hit[k]) begin
        scr_q[k] <= pwdata;
      end
    end
  end

  always_comb begin
    prdata = '0;
    if (paddr == A_CTRL) begin
      prdata[BIT_EN]      = ctrl.en;
      prdata[BIT_PZ_C1]   = ctrl.pz_core1;
      prdata[BIT_PZ_C0]   = ctrl.pz_core0;
      prdata[BIT_PZ_JT]   = ctrl.pz_jtag;
      prdata[CNT_W-1:0]   = count;
    end else if (paddr == A_CAUSE) begin
      prdata[1:0] = cause;
    end else begin
      for (int i = 0; i < N_SCR; i++) begin
        if (scr_hit[i]) prdata = scr_q[i];
      end
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             sys_rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             paused,
  input  logic             load_wr,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic step;
  assign step   = tick & en & ~paused & (count != '0);
  assign expire = step & ~load_wr & (count == CNT_W'(1));

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n)   count <= '0;
    else if (load_wr) count <= load_val;
    else if (step)    count <= count - 1'b1;
  end
endmodule

// File: rtl/wdog_cause.sv
module wdog_cause
  import wdog_pkg::*;
(
  input  logic       clk,
  input  logic       por_n,
  input  logic       force_wr,
  input  logic       expire,
  input  logic       warm_clr,
  output logic [1:0] cause,
  output logic       rst_req
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cause   <= CAUSE_NONE;
      rst_req <= 1'b0;
    end else begin
      rst_req <= force_wr | expire;
      if (force_wr)      cause <= CAUSE_FORCED;
      else if (expire)   cause <= CAUSE_TIMER;
      else if (warm_clr) cause <= CAUSE_NONE;
    end
  end
endmodule

// File: rtl/apb_wdog.sv
module apb_wdog
  import wdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 24,
  parameter int unsigned N_SCR  = 8
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 sys_rst_n,
  input  logic                 tick_us,
  input  logic [1:0]           core_halt,
  input  logic                 jtag_busy,
  input  logic [1:0]           dbg_warm_rst,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [WD_DATA_W-1:0] pwdata,
  output logic [WD_DATA_W-1:0] prdata,
  output logic                 pready,
  output logic                 pslverr,
  output logic                 wdog_rst_req
);
  wd_ctrl_t         ctrl;
  logic             load_wr;
  logic [CNT_W-1:0] load_val;
  logic             force_wr;
  logic [CNT_W-1:0] count;
  logic [1:0]       cause;
  logic             expire;
  logic             paused;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
  assign paused  = (ctrl.pz_core1 & core_halt[1]) |
                   (ctrl.pz_core0 & core_halt[0]) |
                   (ctrl.pz_jtag  & jtag_busy);

  wdog_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .N_SCR(N_SCR)) u_regs (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .count(count), .cause(cause), .prdata(prdata), .ctrl(ctrl),
    .load_wr(load_wr), .load_val(load_val), .force_wr(force_wr)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .sys_rst_n(sys_rst_n), .tick(tick_us), .en(ctrl.en), .paused(paused),
    .load_wr(load_wr), .load_val(load_val), .count(count), .expire(expire)
  );

  wdog_cause u_cause (
    .clk(clk), .por_n(por_n), .force_wr(force_wr), .expire(expire),
    .warm_clr(|dbg_warm_rst), .cause(cause), .rst_req(wdog_rst_req)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int unsigned CNT_W = 24
) (
  input logic             clk,
  input logic             por_n,
  input logic             sys_rst_n,
  input logic             tick_us,
  input logic             en,
  input logic             load_wr,
  input logic             force_wr,
  input logic [CNT_W-1:0] count,
  input logic [1:0]       cause,
  input logic             rst_req,
  input logic             pready,
  input logic             pslverr
);
  // R9
  apb_no_wait_chk: assert property (@(posedge clk) disable iff (!por_n)
    pready && !pslverr);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (!tick_us && !load_wr) |=> $stable(count));

  // R3
  off_hold_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (!en && !load_wr) |=> $stable(count));

  // R5
  zero_sticky_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (count == '0 && !load_wr) |=> (count == '0));

  // R5
  req_cause_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |-> (cause != 2'b00));

  // R6
  force_wins_chk: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    force_wr |=> (rst_req && cause == 2'b10));
endmodule

bind apb_wdog wdog_chk #(.CNT_W(CNT_W)) u_wdog_chk (
  .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .tick_us(tick_us),
  .en(ctrl.en), .load_wr(load_wr), .force_wr(force_wr), .count(count),
  .cause(cause), .rst_req(wdog_rst_req), .pready(pready), .pslverr(pslverr)
);

// File: tb/tb_apb_wdog.sv
module tb_apb_wdog;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        por_n = 1'b0, sys_rst_n = 1'b0;
  logic [1:0]  core_halt = 2'b00, dbg_warm_rst = 2'b00;
  logic        jtag_busy = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, wdog_rst_req;
  logic        auto_tick = 1'b0, man_tick = 1'b0, gen_tick = 1'b0;
  logic        tick_us;
  int          gen_div = 0;
  int          errors = 0, checks = 0;

  assign tick_us = auto_tick ? gen_tick : man_tick;

  apb_wdog dut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .tick_us(tick_us),
    .core_halt(core_halt), .jtag_busy(jtag_busy), .dbg_warm_rst(dbg_warm_rst),
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .pready(pready), .pslverr(pslverr), .wdog_rst_req(wdog_rst_req)
  );

  always @(posedge clk) begin
    #1;
    gen_div  = (gen_div + 1) % 3;
    gen_tick = (gen_div == 0);
  end

  // behavioural reference model
  int          m_cnt;
  bit          m_en, m_p1, m_p0, m_pj, m_req;
  bit [1:0]    m_cause;
  bit [31:0]   m_scr [8];

  function automatic bit [31:0] m_read(input bit [7:0] a);
    if (a == 8'h00) return {1'b0, m_en, 3'b000, m_p1, m_p0, m_pj, 24'(m_cnt)};
    if (a == 8'h08) return {30'd0, m_cause};
    if (a >= 8'h0C && a <= 8'h28 && a[1:0] == 2'b00) return m_scr[(a - 8'h0C) >> 2];
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    bit wr, frc, pz, dec, ex;
    if (!por_n) begin
      m_cnt = 0; m_en = 0; m_p1 = 1; m_p0 = 1; m_pj = 1; m_req = 0; m_cause = 0;
      foreach (m_scr[i]) m_scr[i] = 0;
    end else begin
      wr  = psel && penable && pwrite && sys_rst_n;
      frc = wr && paddr == 8'h00 && pwdata[31];
      pz  = (m_p1 && core_halt[1]) || (m_p0 && core_halt[0]) || (m_pj && jtag_busy);
      dec = sys_rst_n && tick_us && m_en && !pz && m_cnt != 0;
      ex  = dec && m_cnt == 1 && !(wr && paddr == 8'h04);
      m_req = frc || ex;
      if (frc) m_cause = 2'b10;
      else if (ex) m_cause = 2'b01;
      else if (dbg_warm_rst != 0) m_cause = 2'b00;
      if (!sys_rst_n) begin
        m_cnt = 0; m_en = 0; m_p1 = 1; m_p0 = 1; m_pj = 1;
      end else begin
        if (wr && paddr == 8'h04) m_cnt = int'(pwdata[23:0]);
        else if (dec) m_cnt = m_cnt - 1;
        if (wr && paddr == 8'h00) begin
          m_en = pwdata[30]; m_p1 = pwdata[26]; m_p0 = pwdata[25]; m_pj = pwdata[24];
        end
        if (wr && paddr >= 8'h0C && paddr <= 8'h28 && paddr[1:0] == 2'b00)
          m_scr[(paddr - 8'h0C) >> 2] = pwdata;
      end
    end
  end

  task automatic chk(input string tag, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // per-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (por_n) begin
      chk("R5/R6 reset request vs model", {31'd0, wdog_rst_req}, {31'd0, m_req});
      chk("R9 pready/pslverr", {30'd0, pready, pslverr}, 32'h2);
      if (psel && penable && !pwrite) chk("R2/R8 read data vs model", prdata, m_read(paddr));
    end
  end

  task automatic apb_wr(input bit [7:0] a, input bit [31:0] d, input bit tk = 0);
    @(posedge clk); #1 psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(posedge clk); #1 penable = 1; if (tk) man_tick = 1;
    @(posedge clk); #1 psel = 0; penable = 0; pwrite = 0; man_tick = 0;
  endtask

  task automatic apb_rd(input bit [7:0] a, output bit [31:0] d);
    @(posedge clk); #1 psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(posedge clk); #1 penable = 1;
    @(negedge clk); d = prdata;
    @(posedge clk); #1 psel = 0; penable = 0;
  endtask

  task automatic rd_chk(input string tag, input bit [7:0] a, input bit [31:0] exp);
    bit [31:0] v;
    apb_rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 man_tick = 1;
      @(posedge clk); #1 man_tick = 0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: all requirements actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 por_n = 1; sys_rst_n = 1;
    // R1 reset values
    rd_chk("R1 control reset", 8'h00, 32'h0700_0000);
    rd_chk("R1 cause reset", 8'h08, 32'h0);
    rd_chk("R1 scratch reset", 8'h1C, 32'h0);
    chk("R1 request low", {31'd0, wdog_rst_req}, 32'h0);

    // R8 scratch words
    for (int k = 0; k < 8; k++) apb_wr(8'(8'h0C + 4 * k), 32'hA5A5_0000 + 32'(k * 17));
    for (int k = 0; k < 8; k++) rd_chk("R8 scratch readback", 8'(8'h0C + 4 * k), 32'hA5A5_0000 + 32'(k * 17));

    // R2 load and manual ticks
    apb_wr(8'h04, 32'hFF00_000A);
    rd_chk("R2 load register reads zero", 8'h04, 32'h0);
    ticks(2);
    rd_chk("R3 disabled count holds", 8'h00, 32'h0700_000A);
    apb_wr(8'h00, 32'h4000_0000);
    ticks(3);
    rd_chk("R2 three ticks", 8'h00, 32'h4000_0007);

    // R4 pause conditions
    apb_wr(8'h00, 32'h4200_0000);
    core_halt = 2'b01;
    ticks(3);
    rd_chk("R4 core0 halt pauses", 8'h00, 32'h4200_0007);
    core_halt = 2'b10;
    ticks(2);
    rd_chk("R4 core1 halt without enable counts", 8'h00, 32'h4200_0005);
    apb_wr(8'h00, 32'h4500_0000);
    core_halt = 2'b00; jtag_busy = 1;
    ticks(2);
    rd_chk("R4 jtag pauses", 8'h00, 32'h4500_0005);
    jtag_busy = 0;
    ticks(1);
    rd_chk("R4 resumes", 8'h00, 32'h4500_0004);

    // R5 expiry with free-running tick
    apb_wr(8'h04, 32'd40);
    auto_tick = 1;
    repeat (200) @(posedge clk);
    rd_chk("R5 cause timer", 8'h08, 32'h1);
    rd_chk("R5 count stays zero", 8'h00, 32'h4500_0000);
    auto_tick = 0;

    // R7 warm reset clears cause
    @(posedge clk); #1 dbg_warm_rst = 2'b10;
    @(posedge clk); #1 dbg_warm_rst = 2'b00;
    rd_chk("R7 cause cleared", 8'h08, 32'h0);

    // R6 force and same-cycle priority
    apb_wr(8'h04, 32'd1);
    apb_wr(8'h00, 32'hC000_0000, 1'b1);
    rd_chk("R6 force beats expiry", 8'h08, 32'h2);
    rd_chk("R6 force bit reads zero", 8'h00, 32'h4000_0000);
    apb_wr(8'h04, 32'd300);
    apb_wr(8'h00, 32'h8000_0000);
    rd_chk("R6 forced cause", 8'h08, 32'h2);
    rd_chk("R6 count untouched by force", 8'h00, 32'h0000_012C);

    // R9 ignored writes and unmapped space
    apb_wr(8'h08, 32'hFFFF_FFFF);
    rd_chk("R9 cause write ignored", 8'h08, 32'h2);
    apb_wr(8'h00, 32'h38FF_FFFF);
    rd_chk("R9 count field and spare bits ignored", 8'h00, 32'h0000_012C);
    apb_wr(8'h2C, 32'h1234_5678);
    apb_wr(8'h0D, 32'h1234_5678);
    rd_chk("R9 unmapped reads zero", 8'h2C, 32'h0);
    rd_chk("R9 unaligned reads zero", 8'h0D, 32'h0);
    rd_chk("R9 neighbour scratch intact", 8'h0C, 32'hA5A5_0000);

    // R10 / R8 soft reset
    apb_wr(8'h00, 32'h4000_0000);
    @(posedge clk); #1 sys_rst_n = 0;
    repeat (3) @(posedge clk);
    #1 sys_rst_n = 1;
    rd_chk("R10 control after soft reset", 8'h00, 32'h0700_0000);
    rd_chk("R8 cause survives soft reset", 8'h08, 32'h2);
    rd_chk("R8 scratch survives soft reset", 8'h28, 32'hA5A5_0000 + 32'(7 * 17));

    // R1 hardware reset clears scratch and cause
    @(posedge clk); #1 por_n = 0; sys_rst_n = 0;
    repeat (2) @(posedge clk);
    #1 por_n = 1; sys_rst_n = 1;
    rd_chk("R1 scratch cleared by por", 8'h28, 32'h0);
    rd_chk("R1 cause cleared by por", 8'h08, 32'h0);

    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule